// File: doc/BRIEF.md
# Eight-Port Interleaved Word Memory Controller

This block is the controller of one memory module that stores 36-bit words. Eight requesters, typically processors and I/O multiplexers, each own an independent request port. The port's low address bit steers each access to one of two storage banks. Consecutive word addresses therefore alternate between the banks. Each bank has its own round-robin arbiter, so two requests that target different banks are granted in the same cycle and run in parallel. A bank stays occupied for a fixed, parameterised number of cycles after each access. Requests aimed at an occupied bank wait with their valid held high. Read data returns to the port that issued it, as a one-cycle pulse that carries the request's tag.

The module also holds one interrupt cell per port. Any requester can set the cell of any port to signal it. The owning port watches its cell level and clears the cell once it has seen it. If a set and a clear reach the same cell in one cycle, the set wins, so no signal is lost.

The word address is 17 bits wide. The number of address bits a bank actually stores is a parameter (`BANK_AW`). A full-size module sets it to 16. The default is small, and address bits above the implemented depth are ignored.

Top module: `mport_mem_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, with no stimulus, all of `req_ready_o`, `rsp_valid_o` and `irq_pend_o` are zero.
- R2: A read returns the word most recently written at the same address, on the issuing port's `rsp_rdata_o`. The request's tag appears on `rsp_tag_o` with it.
- R3: Address bit 0 selects the bank: 0 is the even bank and 1 is the odd bank. Two requests to different banks that are valid in the same cycle are both granted in that cycle, and their read data arrive in the same cycle.
- R4: `req_ready_o[p]` is the grant. It is high only while `req_valid_i[p]` is high, and each bank grants at most one port per cycle. A port that is not granted keeps waiting.
- R5: If a bank grants in cycle t, it grants nothing in cycles t+1 to t+BUSY_CYC. A request that is waiting for that bank is granted in cycle t+BUSY_CYC+1.
- R6: For a read granted in cycle t, `rsp_valid_o[p]` is high in cycle t+BUSY_CYC+1 only, and only for the issuing port.
- R7: Each bank grants round-robin. The search starts at the port after the one it granted last, wrapping from 7 to 0. After reset, port 0 has the highest priority.
- R8: A write produces no response pulse on any port.
- R9: When a port asserts `irq_set_i` with index n in `irq_set_idx_i`, bit n of `irq_pend_o` is high in the next cycle. Several ports can set different cells in the same cycle.
- R10: Asserting `irq_clr_i[n]` clears cell n in the next cycle and leaves the other cells unchanged. A set and a clear of the same cell in the same cycle leave that cell set.
- R11: Only address bits 1 to BANK_AW are stored. Two addresses that differ only above bit BANK_AW refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PORTS | Request valid, one bit per port, held until granted |
| req_ready_o | output | NUM_PORTS | Grant, one bit per port |
| req_we_i | input | NUM_PORTS | 1 = write, 0 = read |
| req_addr_i | input | NUM_PORTS x ADDR_W | Word address per port |
| req_wdata_i | input | NUM_PORTS x DATA_W | Write data per port |
| req_tag_i | input | NUM_PORTS x TAG_W | Request tag per port, echoed with the read data |
| rsp_valid_o | output | NUM_PORTS | One-cycle read-data valid per port |
| rsp_rdata_o | output | NUM_PORTS x DATA_W | Read data per port |
| rsp_tag_o | output | NUM_PORTS x TAG_W | Echoed tag per port |
| irq_set_i | input | NUM_PORTS | Per-port strobe that sets the cell selected by the port's index |
| irq_set_idx_i | input | NUM_PORTS x PORT_W | Target cell index for each port's set strobe |
| irq_clr_i | input | NUM_PORTS | Per-port clear of that port's own cell |
| irq_pend_o | output | NUM_PORTS | Current state of the cells |

## Verification
The bench puts three requests on the even bank at once and checks that they are granted one at a time, in rotating order, spaced exactly BUSY_CYC+1 cycles apart. A design whose pointer does not advance would keep granting the same port. A design with an off-by-one occupancy counter would shift the spacing. The bench also issues a cross-bank pair in the same cycle, to catch a design that shares one arbiter or serialises independent banks. It checks that the same-cycle set and clear of a cell keeps the cell set, which a design with clear priority would get wrong. Finally, it writes an aliased address and reads it back by its short form, to catch a design that decodes the wrong row bits.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int unsigned NUM_BANKS    = 2;
  localparam int unsigned BANK_SEL_BIT = 0;
endpackage

// File: rtl/mpm_rr_arb.sv
module mpm_rr_arb #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] idx;
  logic          found;

  // search starts one past the last winner
  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    idx       = '0;
    for (int k = 1; k <= int'(N); k++) begin
      idx = IW'((int'(last_q) + k) % int'(N));
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        gnt_idx_o  = idx;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(N - 1);
    else if (found) last_q <= gnt_idx_o;
  end

  // R4
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R4
  gnt_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/mpm_bank.sv
module mpm_bank #(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned ROW_W    = 16,
  parameter int unsigned MEM_AW   = 8,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned PORT_W   = 3,
  parameter int unsigned BUSY_CYC = 3,
  localparam int unsigned DEPTH   = 2 ** MEM_AW,
  localparam int unsigned CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PORT_W-1:0] done_port_o,
  output logic [TAG_W-1:0]  done_tag_o,
  output logic [DATA_W-1:0] done_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] data_q;
  logic [CW-1:0]     cnt_q;
  logic              rd_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PORT_W-1:0] port_q;
  logic [MEM_AW-1:0] row_lo;

  assign row_lo = row_i[MEM_AW-1:0];

  if (ROW_W > MEM_AW) begin : g_alias
    logic unused_hi;
    assign unused_hi = ^row_i[ROW_W-1:MEM_AW];
  end

  always_ff @(posedge clk_i) begin
    if (acc_i && we_i)  mem_q[row_lo] <= wdata_i;
    if (acc_i && !we_i) data_q        <= mem_q[row_lo];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      tag_q  <= '0;
      port_q <= '0;
    end else if (acc_i) begin
      cnt_q  <= CW'(BUSY_CYC);
      rd_q   <= !we_i;
      tag_q  <= tag_i;
      port_q <= port_i;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o      = (cnt_q != '0);
  assign done_o      = rd_q && (cnt_q == CW'(1));
  assign done_port_o = port_q;
  assign done_tag_o  = tag_q;
  assign done_data_o = data_q;

  // R5
  bank_busy_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !acc_i);
  // R8
  write_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i) |=> !done_o);
endmodule

// File: rtl/mpm_irq_cells.sv
module mpm_irq_cells #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          set_i,
  input  logic [N-1:0][IW-1:0]  set_idx_i,
  input  logic [N-1:0]          clr_i,
  output logic [N-1:0]          pend_o
);
  logic [N-1:0] set_hit;
  logic [N-1:0] pend_q;

  always_comb begin
    set_hit = '0;
    for (int n = 0; n < int'(N); n++)
      for (int p = 0; p < int'(N); p++)
        if (set_i[p] && set_idx_i[p] == IW'(n)) set_hit[n] = 1'b1;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= set_hit | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;

  for (genvar p = 0; p < N; p++) begin : g_chk
    // R9
    irq_set_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[p] |=> pend_o[$past(set_idx_i[p])]);
    // R10
    irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[p] && !set_hit[p]) |=> !pend_o[p]);
  end
endmodule

// File: rtl/mport_mem_ctrl.sv
module mport_mem_ctrl #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned DATA_W    = 36,
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned BANK_AW   = 8,
  parameter int unsigned BUSY_CYC  = 3,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PORTS-1:0]                req_valid_i,
  output logic [NUM_PORTS-1:0]                req_ready_o,
  input  logic [NUM_PORTS-1:0]                req_we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    req_addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    req_wdata_i,
  input  logic [NUM_PORTS-1:0][TAG_W-1:0]     req_tag_i,
  output logic [NUM_PORTS-1:0]                rsp_valid_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    rsp_rdata_o,
  output logic [NUM_PORTS-1:0][TAG_W-1:0]     rsp_tag_o,
  input  logic [NUM_PORTS-1:0]                irq_set_i,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0]    irq_set_idx_i,
  input  logic [NUM_PORTS-1:0]                irq_clr_i,
  output logic [NUM_PORTS-1:0]                irq_pend_o
);
  import mpm_pkg::*;

  localparam int unsigned ROW_W = ADDR_W - 1;

  logic [NUM_BANKS-1:0][NUM_PORTS-1:0] bank_req, bank_gnt;
  logic [NUM_BANKS-1:0][PORT_W-1:0]    gnt_idx, done_port;
  logic [NUM_BANKS-1:0]                bank_busy, bank_acc, bank_we, done;
  logic [NUM_BANKS-1:0][ROW_W-1:0]     bank_row;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_wdata, done_data;
  logic [NUM_BANKS-1:0][TAG_W-1:0]     bank_tag, done_tag;

  logic [NUM_PORTS-1:0]                rsp_valid_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    rsp_rdata_q;
  logic [NUM_PORTS-1:0][TAG_W-1:0]     rsp_tag_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      for (int p = 0; p < int'(NUM_PORTS); p++)
        bank_req[b][p] = req_valid_i[p] && !bank_busy[b] &&
                         (req_addr_i[p][BANK_SEL_BIT] == 1'(b));
    end

    mpm_rr_arb #(.N(NUM_PORTS)) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (bank_req[b]),
      .gnt_o     (bank_gnt[b]),
      .gnt_idx_o (gnt_idx[b])
    );

    assign bank_acc[b]   = |bank_gnt[b];
    assign bank_we[b]    = req_we_i[gnt_idx[b]];
    assign bank_row[b]   = req_addr_i[gnt_idx[b]][ADDR_W-1:1];
    assign bank_wdata[b] = req_wdata_i[gnt_idx[b]];
    assign bank_tag[b]   = req_tag_i[gnt_idx[b]];

    mpm_bank #(
      .DATA_W   (DATA_W),
      .ROW_W    (ROW_W),
      .MEM_AW   (BANK_AW),
      .TAG_W    (TAG_W),
      .PORT_W   (PORT_W),
      .BUSY_CYC (BUSY_CYC)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .acc_i       (bank_acc[b]),
      .we_i        (bank_we[b]),
      .row_i       (bank_row[b]),
      .wdata_i     (bank_wdata[b]),
      .tag_i       (bank_tag[b]),
      .port_i      (gnt_idx[b]),
      .busy_o      (bank_busy[b]),
      .done_o      (done[b]),
      .done_port_o (done_port[b]),
      .done_tag_o  (done_tag[b]),
      .done_data_o (done_data[b])
    );
  end

  always_comb begin
    req_ready_o = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) req_ready_o |= bank_gnt[b];
  end

  // fixed latency: one port never completes on both banks at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_rdata_q <= '0;
      rsp_tag_q   <= '0;
    end else begin
      rsp_valid_q <= '0;
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
        if (done[b]) begin
          rsp_valid_q[done_port[b]] <= 1'b1;
          rsp_rdata_q[done_port[b]] <= done_data[b];
          rsp_tag_q[done_port[b]]   <= done_tag[b];
        end
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_tag_o   = rsp_tag_q;

  mpm_irq_cells #(.N(NUM_PORTS)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (irq_set_i),
    .set_idx_i (irq_set_idx_i),
    .clr_i     (irq_clr_i),
    .pend_o    (irq_pend_o)
  );

  // R4
  ready_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
  // R6
  done_port_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done[0] && done[1] && done_port[0] == done_port[1]));
endmodule

// File: tb/mport_mem_ctrl_tb.sv
`timescale 1ns/1ps
module mport_mem_ctrl_tb;
  localparam int NP = 8;
  localparam int DW = 36;
  localparam int AW = 17;
  localparam int TW = 4;
  localparam int BAW = 8;
  localparam int BC = 3;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]         vld = '0, we = '0, iset = '0, iclr = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][DW-1:0] wd = '0;
  logic [NP-1:0][TW-1:0] tg = '0;
  logic [NP-1:0][PW-1:0] iidx = '0;
  logic [NP-1:0]         rdy, rvld, ipend;
  logic [NP-1:0][DW-1:0] rdat;
  logic [NP-1:0][TW-1:0] rtag;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  mport_mem_ctrl #(.NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW), .TAG_W(TW),
                   .BANK_AW(BAW), .BUSY_CYC(BC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(vld), .req_ready_o(rdy), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wd), .req_tag_i(tg),
    .rsp_valid_o(rvld), .rsp_rdata_o(rdat), .rsp_tag_o(rtag),
    .irq_set_i(iset), .irq_set_idx_i(iidx), .irq_clr_i(iclr), .irq_pend_o(ipend)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one access on port p; returns grant cycle; leaves at negedge of gcyc+1
  task automatic single(input int p, input bit w, input int a, input logic [DW-1:0] d,
                        input int t, output int gcyc);
    gcyc = -1;
    @(negedge clk);
    vld[p] = 1'b1; we[p] = w; addr[p] = AW'(a); wd[p] = d; tg[p] = TW'(t);
    for (int it = 0; it < 40; it++) begin
      #1;
      if (rdy[p]) begin
        gcyc = cyc;
        @(negedge clk);
        vld[p] = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_rsp(input int p, input logic [DW-1:0] d, input int t,
                            input int ecyc, input string req);
    int seen = -1;
    logic [DW-1:0] sd = '0;
    logic [TW-1:0] st = '0;
    bit again = 0, others = 0;
    for (int it = 0; it < BC + 6; it++) begin
      #1;
      if (rvld[p]) begin
        if (seen < 0) begin seen = cyc; sd = rdat[p]; st = rtag[p]; end
        else again = 1;
      end
      if ((rvld & ~(NP'(1) << p)) != '0) others = 1;
      @(negedge clk);
    end
    chk(seen == ecyc, req, "R6 response cycle", 64'(seen), 64'(ecyc));
    chk(sd == d, req, "read data", 64'(sd), 64'(d));
    chk(st == TW'(t), req, "echoed tag", 64'(st), 64'(t));
    chk(!again && !others, "R6", "single pulse on own port only", 64'(again), 64'(0));
  endtask

  task automatic t_reset();
    idle(3);
    #1;
    chk(rdy == '0 && rvld == '0 && ipend == '0, "R1", "outputs in reset",
        64'({rdy, rvld, ipend}), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    idle(2); #1;
    chk(rdy == '0 && rvld == '0 && ipend == '0, "R1", "outputs after reset",
        64'({rdy, rvld, ipend}), 64'(0));
  endtask

  task automatic t_write_read();
    int g;
    single(3, 1'b1, 5, 36'h9_A5A5_1234, 1, g);
    for (int it = 0; it < BC + 3; it++) begin
      #1; chk(rvld == '0, "R8", "no response to write", 64'(rvld), 64'(0));
      @(negedge clk);
    end
    single(3, 1'b0, 5, '0, 9, g);
    expect_rsp(3, 36'h9_A5A5_1234, 9, g + BC + 1, "R2");
  endtask

  task automatic t_parallel();
    int g, c;
    bit both = 0, rsp_ok = 0;
    single(1, 1'b1, 4, 36'h1_0000_BEEF, 0, g);
    idle(BC + 2);
    vld[0] = 1; we[0] = 0; addr[0] = AW'(5); tg[0] = 4'h7;
    vld[1] = 1; we[1] = 0; addr[1] = AW'(4); tg[1] = 4'h8;
    #1;
    both = rdy[0] && rdy[1];
    c = cyc;
    chk(both, "R3", "cross-bank pair granted together", 64'(rdy), 64'(3));
    @(negedge clk); vld[0] = 0; vld[1] = 0;
    while (cyc < c + BC + 1) @(negedge clk);
    #1;
    rsp_ok = (rvld == NP'(3)) && rdat[0] == 36'h9_A5A5_1234 && rdat[1] == 36'h1_0000_BEEF &&
             rtag[0] == 4'h7 && rtag[1] == 4'h8;
    chk(rsp_ok, "R3", "both responses same cycle", 64'(rvld), 64'(3));
    idle(BC + 3);
  endtask

  function automatic int next_req(input int from, input logic [NP-1:0] set);
    for (int k = 1; k <= NP; k++)
      if (set[(from + k) % NP]) return (from + k) % NP;
    return -1;
  endfunction

  task automatic t_round_robin();
    int g[3], gc[3];
    int n = 0, first = -1;
    bit multi = 0;
    logic [NP-1:0] drop, set1;
    set1 = NP'(8'b0110_0100);
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      if (set1[p]) begin vld[p] = 1; we[p] = 0; addr[p] = AW'(10 + 2 * p); tg[p] = TW'(p); end
    for (int it = 0; it < 40 && n < 3; it++) begin
      #1;
      if ($countones(rdy) > 1) multi = 1;
      for (int p = 0; p < NP; p++)
        if (rdy[p]) begin if (n < 3) begin g[n] = p; gc[n] = cyc; end n++; end
      drop = rdy;
      @(negedge clk); vld = vld & ~drop;
    end
    chk(n == 3 && !multi, "R4", "one grant per cycle on a bank", 64'(n), 64'(3));
    chk(g[1] == next_req(g[0], set1), "R7", "second winner", 64'(g[1]), 64'(next_req(g[0], set1)));
    chk(g[2] == next_req(g[1], set1), "R7", "third winner", 64'(g[2]), 64'(next_req(g[1], set1)));
    chk(gc[1] - gc[0] == BC + 1, "R5", "grant spacing 1", 64'(gc[1] - gc[0]), 64'(BC + 1));
    chk(gc[2] - gc[1] == BC + 1, "R5", "grant spacing 2", 64'(gc[2] - gc[1]), 64'(BC + 1));
    idle(BC + 3);
    vld[0] = 1; we[0] = 0; addr[0] = AW'(30); tg[0] = 0;
    vld[7] = 1; we[7] = 0; addr[7] = AW'(32); tg[7] = 7;
    for (int it = 0; it < 20 && vld != '0; it++) begin
      #1;
      for (int p = 0; p < NP; p++) if (rdy[p] && first < 0) first = p;
      drop = rdy;
      @(negedge clk); vld = vld & ~drop;
    end
    chk(first == next_req(g[2], NP'(8'b1000_0001)), "R7", "rotation resumes after last winner",
        64'(first), 64'(next_req(g[2], NP'(8'b1000_0001))));
    idle(BC + 4);
  endtask

  task automatic t_busy();
    int c, first7 = -1;
    bit ok1 = 0;
    logic [NP-1:0] drop;
    single(4, 1'b0, 20, '0, 4, c);
    vld[7] = 1; we[7] = 0; addr[7] = AW'(22); tg[7] = 7;
    vld[1] = 1; we[1] = 0; addr[1] = AW'(21); tg[1] = 1;
    for (int it = 0; it < BC + 4; it++) begin
      #1;
      if (cyc == c + 1 && rdy[1]) ok1 = 1;
      if (rdy[7] && first7 < 0) first7 = cyc;
      drop = rdy;
      @(negedge clk); vld = vld & ~drop;
    end
    vld = '0;
    chk(ok1, "R3", "other bank free while one is busy", 64'(ok1), 64'(1));
    chk(first7 == c + BC + 1, "R5", "waiting request granted when bank frees",
        64'(first7), 64'(c + BC + 1));
    idle(BC + 4);
  endtask

  task automatic t_alias();
    int g;
    single(6, 1'b1, 6 + (1 << (BAW + 1)), 36'hF_0F0F_0F0F, 0, g);
    idle(BC + 1);
    single(6, 1'b0, 6, '0, 3, g);
    expect_rsp(6, 36'hF_0F0F_0F0F, 3, g + BC + 1, "R11");
  endtask

  task automatic t_irq();
    @(negedge clk); iset[2] = 1; iidx[2] = 3'd5;
    @(negedge clk); iset = '0; #1;
    chk(ipend == 8'h20, "R9", "cell set by another port", 64'(ipend), 64'h20);
    @(negedge clk); iclr[5] = 1;
    @(negedge clk); iclr = '0; #1;
    chk(ipend == 8'h00, "R10", "owner clears cell", 64'(ipend), 64'h00);
    @(negedge clk); iset[0] = 1; iidx[0] = 3'd5; iset[3] = 1; iidx[3] = 3'd1; iclr[5] = 1;
    @(negedge clk); iset = '0; iclr = '0; #1;
    chk(ipend == 8'h22, "R10", "set wins over clear, two cells at once", 64'(ipend), 64'h22);
    @(negedge clk); iclr[1] = 1;
    @(negedge clk); iclr = '0; #1;
    chk(ipend == 8'h20, "R10", "clear leaves other cells", 64'(ipend), 64'h20);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_parallel();
    t_round_robin();
    t_busy();
    t_alias();
    t_irq();
    idle(2);
    summary();
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
  end
endmodule